// File: doc/BRIEF.md
# Reload Timer with Event Counting

The block is a down-counting reload timer. When its count is zero and a count step arrives, the counter reloads from a reload register, sets a sticky interrupt flag and toggles a dedicated timer output. The count step comes from one of two sources. In internal mode it is a prescaled tick at half the system clock rate. In external mode it is a chosen edge on an event input. The edge can be rising only, falling only, or both. The event input is synchronised through a flip-flop chain before edge detection.

Software controls the block through a small write port and a combinational read port. One control register selects the count source, the active edge, one-shot or continuous operation, run/stop and the interrupt enable. It also holds a trigger bit and the sticky flag. A second register holds the reload value. The live count can be read back.

Top module: `evtReloadTimer`

## Requirements
- R1: After reset the count, the reload register and every control bit read as zero, and `timerOut` and `irq` are low.
- R2: In internal mode (control bit 2 = 0) with the run bit (bit 0) set, the counter decrements by one every second clock cycle. The first decrement comes two cycles after the start.
- R3: In external mode (bit 2 = 1), the edge field in bits 4:3 picks the active edge: 01 rising, 10 falling, 11 both, 00 none. Each active edge of `evtIn` decrements the counter once. The count changes on the third rising clock edge after the input changes, because of the two-stage synchroniser and the edge register.
- R4: A count step that arrives while the count is zero loads the reload value, sets the sticky flag (bit 7) and toggles `timerOut`.
- R5: With the one-shot bit (bit 5) clear, the timer keeps running after an underflow. With it set, the run bit is cleared by the first underflow, and the counter then holds the reload value.
- R6: Writing the control register with the trigger bit (bit 1) set loads the reload value into the counter and sets the run bit. The trigger bit always reads back as zero.
- R7: With the run bit clear, the counter holds its value.
- R8: `irq` equals the sticky flag AND the interrupt enable (bit 6). A control write with bit 7 = 0 clears the flag. A write with bit 7 = 1 leaves the flag as it is.
- R9: Read address 0 returns the control register, address 1 the reload value and address 2 the live count. Write address 0 writes control and address 1 writes reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address (0 control, 1 reload) |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address (0 control, 1 reload, 2 count) |
| rdData | output | 16 | Read data, combinational |
| evtIn | input | 1 | Asynchronous external event input |
| timerOut | output | 1 | Timer output, toggles on each underflow |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default values: a 16-bit counter and a two-stage synchroniser. These keep the three-cycle edge latency and the two-cycle internal tick period small, so the bench can predict them exactly. A 16-bit reload value is large enough to test counting without underflow. Reload values of zero and three bring underflow and reload within a few event pulses. A run of both-edge counts crosses zero in the middle of the pulse train.

// File: rtl/rldtmr_pkg.sv
package rldtmr_pkg;
  localparam int ADDR_W      = 2;
  localparam int CTRL_W      = 8;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd2;

  localparam int BIT_RUN     = 0;
  localparam int BIT_TRIG    = 1;
  localparam int BIT_EXT     = 2;
  localparam int BIT_EDGE_LO = 3;
  localparam int BIT_EDGE_HI = 4;
  localparam int BIT_ONESHOT = 5;
  localparam int BIT_IRQEN   = 6;
  localparam int BIT_FLAG    = 7;

  typedef struct packed {
    logic load;
    logic tick;
    logic reloadWe;
  } dpStrobe_t;
endpackage

// File: rtl/rldtmr_ctrl.sv
module rldtmr_ctrl
  import rldtmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              evtIn,
  input  logic              underflow,
  output dpStrobe_t         strobes,
  output logic [CTRL_W-1:0] ctrlView,
  output logic              timerOut,
  output logic              irq
);
  logic runBit, extMode, oneShot, irqEn, flagQ, outQ, preQ;
  logic [1:0] edgeSel;
  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ, rise, fall, evtHit;
  logic ctrlWr, trig, intTick, extTick;

  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);
  assign trig   = ctrlWr && wrData[BIT_TRIG];

  // input synchroniser chain
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= evtIn;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], evtIn};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[SYNC_STAGES-1];

  assign rise   = syncQ[SYNC_STAGES-1] & ~prevQ;
  assign fall   = ~syncQ[SYNC_STAGES-1] & prevQ;
  assign evtHit = (edgeSel[0] & rise) | (edgeSel[1] & fall);

  assign intTick = runBit & ~extMode & preQ;
  assign extTick = runBit & extMode & evtHit;

  always_comb begin
    strobes.load     = trig;
    strobes.tick     = (intTick | extTick) & ~trig;
    strobes.reloadWe = wrEn && (wrAddr == ADDR_RELOAD);
  end

  // prescaler: half system clock
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                  preQ <= 1'b0;
    else if (trig || !runBit)   preQ <= 1'b0;
    else if (!extMode)          preQ <= ~preQ;

  // control fields
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      extMode <= 1'b0;
      edgeSel <= 2'b00;
      oneShot <= 1'b0;
      irqEn   <= 1'b0;
    end else if (ctrlWr) begin
      extMode <= wrData[BIT_EXT];
      edgeSel <= wrData[BIT_EDGE_HI:BIT_EDGE_LO];
      oneShot <= wrData[BIT_ONESHOT];
      irqEn   <= wrData[BIT_IRQEN];
    end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                     runBit <= 1'b0;
    else if (trig)                 runBit <= 1'b1;
    else if (ctrlWr)               runBit <= wrData[BIT_RUN];
    else if (underflow && oneShot) runBit <= 1'b0;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                               flagQ <= 1'b0;
    else if (underflow)                      flagQ <= 1'b1;
    else if (ctrlWr && !wrData[BIT_FLAG])    flagQ <= 1'b0;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)          outQ <= 1'b0;
    else if (underflow) outQ <= ~outQ;

  assign timerOut = outQ;
  assign irq      = flagQ & irqEn;
  assign ctrlView = {flagQ, irqEn, oneShot, edgeSel, extMode, 1'b0, runBit};

  // R2: internal ticks never on back-to-back cycles
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    intTick |=> !intTick);
  // R4: the output changes only after an underflow
  a_r4_out_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (outQ != $past(outQ)) |-> $past(underflow));
  // R4 / R8: underflow leaves the flag set
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> flagQ);
  // R5: one-shot underflow stops the timer
  a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && oneShot && !ctrlWr) |=> !runBit);
  // R6: trigger starts the timer
  a_r6_trig_run: assert property (@(posedge clk) disable iff (!rstN)
    trig |=> runBit);
endmodule

// File: rtl/rldtmr_datapath.sv
module rldtmr_datapath
  import rldtmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobes,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reloadVal,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cntQ, rldQ;
  logic atZero;

  assign atZero    = (cntQ == ZERO);
  assign underflow = strobes.tick && atZero;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                 rldQ <= ZERO;
    else if (strobes.reloadWe) rldQ <= wrData;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)             cntQ <= ZERO;
    else if (strobes.load) cntQ <= rldQ;
    else if (strobes.tick) cntQ <= atZero ? rldQ : (cntQ - ONE);

  assign count     = cntQ;
  assign reloadVal = rldQ;

  // R4: a step at zero reloads
  a_r4_reload: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && !strobes.load && cntQ == ZERO) |=> (cntQ == $past(rldQ)));
  // R2 / R3: a step away from zero decrements by one
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && !strobes.load && cntQ != ZERO) |=> (cntQ == $past(cntQ) - ONE));
  // R7: no step, no load, no change
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.tick && !strobes.load) |=> $stable(cntQ));
  // R6: load and step never coincide
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.tick && strobes.load));
endmodule

// File: rtl/evtReloadTimer.sv
module evtReloadTimer
  import rldtmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  input  logic              evtIn,
  output logic              timerOut,
  output logic              irq
);
  dpStrobe_t strobes;
  logic [CTRL_W-1:0] ctrlView;
  logic [CNT_W-1:0]  count, reloadVal;
  logic              underflow;

  rldtmr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData[CTRL_W-1:0]), .evtIn(evtIn), .underflow(underflow),
    .strobes(strobes), .ctrlView(ctrlView), .timerOut(timerOut), .irq(irq)
  );

  rldtmr_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .count(count), .reloadVal(reloadVal), .underflow(underflow)
  );

  // R9: read mux
  always_comb begin
    case (rdAddr)
      ADDR_CTRL:   rdData = {{(CNT_W-CTRL_W){1'b0}}, ctrlView};
      ADDR_RELOAD: rdData = reloadVal;
      ADDR_COUNT:  rdData = count;
      default:     rdData = '0;
    endcase
  end
endmodule

// File: tb/evtReloadTimer_tb.sv
module evtReloadTimer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [15:0] rdData;
  logic evtIn = 1'b0;
  logic timerOut, irq;
  int nTests = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  evtReloadTimer dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evtIn(evtIn),
    .timerOut(timerOut), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [15:0] rld;
    logic [7:0]  pulses;
    logic [15:0] expCnt;
    logic        expFlag;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{sel: 2'b01, rld: 16'd100, pulses: 8'd5, expCnt: 16'd95,  expFlag: 1'b0},
    '{sel: 2'b10, rld: 16'd100, pulses: 8'd5, expCnt: 16'd95,  expFlag: 1'b0},
    '{sel: 2'b11, rld: 16'd100, pulses: 8'd5, expCnt: 16'd90,  expFlag: 1'b0},
    '{sel: 2'b00, rld: 16'd100, pulses: 8'd5, expCnt: 16'd100, expFlag: 1'b0},
    '{sel: 2'b11, rld: 16'd3,   pulses: 8'd3, expCnt: 16'd1,   expFlag: 1'b1},
    '{sel: 2'b01, rld: 16'd0,   pulses: 8'd2, expCnt: 16'd0,   expFlag: 1'b1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [15:0] rd(input logic [1:0] a);
    rdAddr = a;
    return rdData;
  endfunction

  task automatic readChk(input string req, input logic [1:0] a, input logic [15:0] exp);
    rdAddr = a;
    #1;
    check(req, rdData, exp);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    readChk("R1 ctrl", 2'd0, 16'h0000);
    readChk("R1 reload", 2'd1, 16'h0000);
    readChk("R1 count", 2'd2, 16'h0000);
    check("R1 timerOut", {15'd0, timerOut}, 16'd0);
    check("R1 irq", {15'd0, irq}, 16'd0);
    rstN = 1'b1;
    @(negedge clk);
    readChk("R1 count after release", 2'd2, 16'h0000);

    // vector table: external edge counting (R3, R4)
    for (int i = 0; i < 6; i++) begin
      wr(2'd1, VEC[i].rld);
      wr(2'd0, {11'd0, VEC[i].sel, 1'b1, 1'b1, 1'b0}); // ext, trig, flag cleared
      for (int p = 0; p < int'(VEC[i].pulses); p++) begin
        evtIn = 1'b1; repeat (3) @(negedge clk);
        evtIn = 1'b0; repeat (3) @(negedge clk);
      end
      repeat (2) @(negedge clk);
      readChk("R3 edge count", 2'd2, VEC[i].expCnt);
      rdAddr = 2'd0; #1;
      check("R4 flag after edges", {15'd0, rdData[7]}, {15'd0, VEC[i].expFlag});
    end

    // R3: synchroniser latency, both edges
    wr(2'd1, 16'd50);
    wr(2'd0, 16'h001E);
    evtIn = 1'b1;
    repeat (2) @(negedge clk);
    readChk("R3 no count after two edges", 2'd2, 16'd50);
    @(negedge clk);
    readChk("R3 count on third edge", 2'd2, 16'd49);
    evtIn = 1'b0;
    repeat (4) @(negedge clk);
    readChk("R3 falling counted once", 2'd2, 16'd48);

    // R2 internal mode, R4 underflow, R5 continuous, R8 irq
    wr(2'd1, 16'd4);
    held = timerOut ? 16'd1 : 16'd0;
    wr(2'd0, 16'h0042);
    readChk("R6 trigger loads reload", 2'd2, 16'd4);
    readChk("R6 trig reads zero", 2'd0, 16'h0041);
    repeat (3) @(negedge clk);
    readChk("R2 one decrement at k3", 2'd2, 16'd3);
    repeat (6) @(negedge clk);
    readChk("R2 zero at k9", 2'd2, 16'd0);
    check("R8 irq low before underflow", {15'd0, irq}, 16'd0);
    @(negedge clk);
    readChk("R4 reload at underflow", 2'd2, 16'd4);
    check("R4 out toggled", {15'd0, timerOut}, held ^ 16'd1);
    check("R8 irq raised", {15'd0, irq}, 16'd1);
    repeat (10) @(negedge clk);
    readChk("R5 continuous second reload", 2'd2, 16'd4);
    check("R4 out toggled back", {15'd0, timerOut}, held);
    wr(2'd0, 16'h00C1);
    check("R8 write one keeps flag", {15'd0, irq}, 16'd1);
    wr(2'd0, 16'h0041);
    check("R8 write zero clears flag", {15'd0, irq}, 16'd0);

    // R7 stop
    wr(2'd0, 16'h0000);
    held = rd(2'd2);
    repeat (6) @(negedge clk);
    readChk("R7 frozen when stopped", 2'd2, held);

    // R5 one-shot
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h0062);
    repeat (8) @(negedge clk);
    readChk("R5 one-shot run cleared", 2'd0, 16'h00E0);
    readChk("R5 one-shot holds reload", 2'd2, 16'd2);
    check("R8 irq after one-shot", {15'd0, irq}, 16'd1);
    repeat (4) @(negedge clk);
    readChk("R5 one-shot stays stopped", 2'd2, 16'd2);
    wr(2'd0, 16'h00A0);
    check("R8 irq masked by enable", {15'd0, irq}, 16'd0);
    readChk("R8 flag still set", 2'd0, 16'h00A0);
    readChk("R9 reload readback", 2'd1, 16'd2);
    readChk("R9 unused address", 2'd3, 16'd0);

    finishRun();
  end
endmodule